// File: doc/BRIEF.md
# Time-Slotted Shared Memory Hub

The hub arbitrates one shared main memory among eight processor cores by strict time division. A free-running slot counter hands the memory to one core per clock cycle in a fixed rotation, so each core owns one cycle in every eight. Whether or not other cores are asking has no effect on this. A core raises a request with a size, an address and write data. It holds that request until its own slot comes round. One cycle after the slot, the hub pulses that core's ready line for one cycle.

In its slot a core can move a byte, a 16-bit word, a 32-bit long, or a group of four longs aligned to a 16-byte boundary. The storage is four parallel 32-bit banks, selected by byte-address bits [3:2]. This lets a four-long group travel over a 128-bit path in a single slot. Narrow writes use per-byte lane enables, so the untouched bytes of a long keep their values. Narrow reads come back zero-extended. Read data goes out on one response bus that all cores share, and it is valid for the core whose ready line is high. The default address width gives a small array. Setting ADDR_W to 17 gives the full 128 KB.

Top module: `hub_mem`

## Requirements
- R1: Reset sets the slot counter to 0. After that the counter steps 0,1,...,7,0 on every clock, whatever the requests are.
- R2: A request from core k is served only on a clock edge where the slot equals k. ready_o[k] is high for exactly the one cycle after that edge, and a held request waits at most 8 clock edges.
- R3: At most one bit of ready_o is high in any cycle.
- R4: When the slot owner has no request, the slot is spent with no memory access and no ready pulse.
- R5: size_i encodes the transfer: 0 is a byte, 1 is a 16-bit word, 2 is a 32-bit long, 3 is four longs.
- R6: A byte write changes only the byte at its address, and the other three bytes of that long are preserved. A byte read returns that byte in rdata_o[7:0] with all other bits zero.
- R7: A word access ignores address bit 0. Address bit 1 picks the upper or lower half of the long. A word read returns the half in rdata_o[15:0] with all other bits zero.
- R8: A long access ignores address bits [1:0] and reads or writes the whole long, returned in rdata_o[31:0] with the upper 96 bits zero. A write to one long leaves the neighbouring longs unchanged.
- R9: A four-long access ignores address bits [3:0] and moves all four longs of the 16-byte group in one slot. The long at group base + 4*i maps to bits [32*i+31:32*i] of the data.
- R10: ready_o is low while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_CORES | Per-core request, held until ready |
| we_i | input | NUM_CORES | Per-core write select (1 = write) |
| size_i | input | NUM_CORES x 2 | Per-core transfer size code |
| addr_i | input | NUM_CORES x ADDR_W | Per-core byte address |
| wdata_i | input | NUM_CORES x 128 | Per-core write data; narrow sizes use the low bits |
| ready_o | output | NUM_CORES | One-cycle completion pulse per core |
| rdata_o | output | 128 | Shared read data, valid with the ready pulse of a read |

## Verification
A table of single requests moves through all four sizes on different cores. It includes byte and word writes into a long that was already written, which separates correct lane enables from whole-long overwrites. It also includes misaligned addresses, which show whether the low bits are ignored rather than used. A separate long in the next bank shows that bank selection keeps neighbours apart. A four-long write with a non-zero offset, followed by a long read and a four-long read, confirms the single-slot group move and its bit order. When all eight cores request at once, the ready pulses must come out in slot order, one per cycle. An idle stretch must show no ready pulse at all.

// File: rtl/hub_pkg.sv
package hub_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_QUAD = 2'd3
  } size_e;

  localparam int unsigned LANES    = 4;
  localparam int unsigned LONG_W   = 32;
  localparam int unsigned LINE_W   = LANES * LONG_W;
endpackage

// File: rtl/hub_slot_ctr.sv
module hub_slot_ctr #(
  parameter int unsigned NUM_SLOTS = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [SLOT_W-1:0] slot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                slot_o <= '0;
    else if (slot_o == SLOT_W'(NUM_SLOTS - 1))  slot_o <= '0;
    else                                        slot_o <= slot_o + 1'b1;
  end
endmodule

// File: rtl/hub_bank.sv
module hub_bank #(
  parameter int unsigned ROW_W = 8,
  localparam int unsigned DEPTH = 1 << ROW_W
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [3:0]       be_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [31:0]      wd_i,
  output logic [31:0]      rd_o
);
  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) begin
        for (int b = 0; b < 4; b++)
          if (be_i[b]) mem_q[row_i][8*b +: 8] <= wd_i[8*b +: 8];
      end else begin
        rd_o <= mem_q[row_i];
      end
    end
  end
endmodule

// File: rtl/hub_lane_ctrl.sv
module hub_lane_ctrl
  import hub_pkg::*;
(
  input  logic              we_i,
  input  size_e             size_i,
  input  logic [3:0]        lo_i,
  input  logic [LINE_W-1:0] wdata_i,
  output logic [LANES-1:0]  bank_we_o,
  output logic [LANES-1:0][3:0]        bank_be_o,
  output logic [LANES-1:0][LONG_W-1:0] bank_wd_o
);
  logic [3:0] be_narrow;
  logic [31:0] wd_narrow;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: begin
        be_narrow = 4'b0001 << lo_i[1:0];
        wd_narrow = {4{wdata_i[7:0]}};
      end
      SZ_WORD: begin
        be_narrow = lo_i[1] ? 4'b1100 : 4'b0011;
        wd_narrow = {2{wdata_i[15:0]}};
      end
      default: begin
        be_narrow = 4'b1111;
        wd_narrow = wdata_i[31:0];
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (size_i == SZ_QUAD) begin
        bank_we_o[g] = we_i;
        bank_be_o[g] = 4'b1111;
        bank_wd_o[g] = wdata_i[LONG_W*g +: LONG_W];
      end else begin
        bank_we_o[g] = we_i && (lo_i[3:2] == 2'(g));
        bank_be_o[g] = be_narrow;
        bank_wd_o[g] = wd_narrow;
      end
    end
  end
endmodule

// File: rtl/hub_rd_fmt.sv
module hub_rd_fmt
  import hub_pkg::*;
(
  input  size_e             size_i,
  input  logic [3:0]        lo_i,
  input  logic [LANES-1:0][LONG_W-1:0] bank_rd_i,
  output logic [LINE_W-1:0] rdata_o
);
  logic [31:0] long_sel;
  logic [31:0] shifted;

  assign long_sel = bank_rd_i[lo_i[3:2]];
  assign shifted  = long_sel >> {lo_i[1:0], 3'b000};

  always_comb begin
    rdata_o = '0;
    unique case (size_i)
      SZ_BYTE: rdata_o[7:0]   = shifted[7:0];
      SZ_WORD: rdata_o[15:0]  = lo_i[1] ? long_sel[31:16] : long_sel[15:0];
      SZ_LONG: rdata_o[31:0]  = long_sel;
      default: rdata_o        = bank_rd_i;
    endcase
  end
endmodule

// File: rtl/hub_mem.sv
module hub_mem
  import hub_pkg::*;
#(
  parameter int unsigned NUM_CORES = 8,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CORES-1:0]             req_i,
  input  logic [NUM_CORES-1:0]             we_i,
  input  logic [NUM_CORES-1:0][1:0]        size_i,
  input  logic [NUM_CORES-1:0][ADDR_W-1:0] addr_i,
  input  logic [NUM_CORES-1:0][127:0]      wdata_i,
  output logic [NUM_CORES-1:0]             ready_o,
  output logic [127:0]                     rdata_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_CORES);
  localparam int unsigned ROW_W  = ADDR_W - 4;

  logic [SLOT_W-1:0] slot_q;
  logic              grant;
  logic              sel_we;
  size_e             sel_size;
  logic [ADDR_W-1:0] sel_addr;
  logic [LINE_W-1:0] sel_wdata;

  logic [LANES-1:0]              bank_we;
  logic [LANES-1:0][3:0]         bank_be;
  logic [LANES-1:0][LONG_W-1:0]  bank_wd;
  logic [LANES-1:0][LONG_W-1:0]  bank_rd;

  size_e      rsp_size_q;
  logic [3:0] rsp_lo_q;

  hub_slot_ctr #(.NUM_SLOTS(NUM_CORES)) u_slot (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_o(slot_q)
  );

  // owner mux: only the slot holder reaches the array
  assign grant     = req_i[slot_q];
  assign sel_we    = we_i[slot_q];
  assign sel_size  = size_e'(size_i[slot_q]);
  assign sel_addr  = addr_i[slot_q];
  assign sel_wdata = wdata_i[slot_q];

  hub_lane_ctrl u_lane (
    .we_i     (sel_we),
    .size_i   (sel_size),
    .lo_i     (sel_addr[3:0]),
    .wdata_i  (sel_wdata),
    .bank_we_o(bank_we),
    .bank_be_o(bank_be),
    .bank_wd_o(bank_wd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    hub_bank #(.ROW_W(ROW_W)) u_bank (
      .clk_i(clk_i),
      .en_i (grant),
      .we_i (bank_we[g]),
      .be_i (bank_be[g]),
      .row_i(sel_addr[ADDR_W-1:4]),
      .wd_i (bank_wd[g]),
      .rd_o (bank_rd[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o    <= '0;
      rsp_size_q <= SZ_LONG;
      rsp_lo_q   <= '0;
    end else begin
      ready_o <= '0;
      if (grant) begin
        ready_o[slot_q] <= 1'b1;
        rsp_size_q      <= sel_size;
        rsp_lo_q        <= sel_addr[3:0];
      end
    end
  end

  hub_rd_fmt u_fmt (
    .size_i   (rsp_size_q),
    .lo_i     (rsp_lo_q),
    .bank_rd_i(bank_rd),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/hub_mem_chk.sv
module hub_mem_chk #(
  parameter int unsigned NUM_CORES = 8,
  localparam int unsigned SLOT_W = $clog2(NUM_CORES)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [SLOT_W-1:0]    slot_i,
  input logic [NUM_CORES-1:0] req_i,
  input logic [NUM_CORES-1:0] ready_o
);
  localparam logic [NUM_CORES-1:0] ONE = NUM_CORES'(1);

  AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> slot_i == (($past(slot_i) == SLOT_W'(NUM_CORES - 1)) ? '0 : $past(slot_i) + 1'b1)); // R1

  AST_READY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ready_o)); // R3

  AST_READY_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o != '0) |-> ready_o == (ONE << $past(slot_i))); // R2

  AST_READY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o != '0) |-> $past(req_i[slot_i])); // R4

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_pulse
    AST_READY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o[k] |=> !ready_o[k]); // R2
  end

  AST_RESET_READY: assert property (@(posedge clk_i)
    !rst_ni |-> ready_o == '0); // R10
endmodule

bind hub_mem hub_mem_chk #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .slot_i (slot_q),
  .req_i  (req_i),
  .ready_o(ready_o)
);

// File: tb/sim_hub_mem.sv
module sim_hub_mem;
  localparam int  NC     = 8;
  localparam int  AW     = 12;
  localparam time CLK_PD = 10ns;
  localparam int  NVEC   = 12;

  // {core[3], we[1], size[2], addr[12], wdata[32], expect[32]}
  localparam logic [81:0] VECS [NVEC] = '{
    {3'd0, 1'b1, 2'd2, 12'h040, 32'hAABBCCDD, 32'h0},         // R8 long write
    {3'd3, 1'b0, 2'd2, 12'h042, 32'h0,        32'hAABBCCDD},  // R8 low bits ignored
    {3'd5, 1'b1, 2'd0, 12'h041, 32'h00000011, 32'h0},         // R6 byte write
    {3'd1, 1'b0, 2'd2, 12'h040, 32'h0,        32'hAABB11DD},  // R6 neighbours kept
    {3'd2, 1'b0, 2'd0, 12'h043, 32'h0,        32'h000000AA},  // R6 byte read
    {3'd7, 1'b1, 2'd1, 12'h043, 32'h00005566, 32'h0},         // R7 bit0 ignored
    {3'd4, 1'b0, 2'd1, 12'h042, 32'h0,        32'h00005566},  // R7 upper half
    {3'd6, 1'b0, 2'd1, 12'h041, 32'h0,        32'h000011DD},  // R7 lower half
    {3'd0, 1'b0, 2'd2, 12'h040, 32'h0,        32'h556611DD},  // R5 R8
    {3'd2, 1'b1, 2'd2, 12'h044, 32'h01234567, 32'h0},         // R8 next bank
    {3'd1, 1'b0, 2'd2, 12'h040, 32'h0,        32'h556611DD},  // R8 isolation
    {3'd3, 1'b0, 2'd0, 12'h044, 32'h0,        32'h00000067}   // R6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]          req = '0;
  logic [NC-1:0]          we = '0;
  logic [NC-1:0][1:0]     size = '0;
  logic [NC-1:0][AW-1:0]  addr = '0;
  logic [NC-1:0][127:0]   wdata = '0;
  logic [NC-1:0]          ready;
  logic [127:0]           rdata;

  int n_chk = 0;
  int n_fail = 0;
  int edge_cnt;

  always #(CLK_PD / 2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;

  hub_mem #(.NUM_CORES(NC), .ADDR_W(AW)) u0 (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .we_i   (we),
    .size_i (size),
    .addr_i (addr),
    .wdata_i(wdata),
    .ready_o(ready),
    .rdata_o(rdata)
  );

  task automatic check(input logic ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_op(input int c, input logic w, input logic [1:0] sz,
                       input logic [AW-1:0] a, input logic [127:0] wd,
                       output logic [127:0] rd);
    int waited = 0;
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; size[c] = sz; addr[c] = a; wdata[c] = wd;
    do begin
      @(negedge clk);
      waited++;
    end while (!ready[c] && waited < 20);
    rd = rdata;
    // R2: served in own slot within 8 edges; R3: only this core ready
    check(ready == (NC'(1) << c) && ((edge_cnt - 1) % NC) == c && waited <= NC,
          "R2/R3 slot", 128'(ready), 128'(NC'(1) << c));
    req[c] = 1'b0;
  endtask

  initial begin
    #(CLK_PD * 50000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] rd;
    logic [127:0] qd;
    logic [NC-1:0] pend;
    int spurious;

    repeat (3) @(negedge clk);
    check(ready == '0, "R10 reset", 128'(ready), 128'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [81:0] v;
      v = VECS[i];
      do_op(int'(v[81:79]), v[78], v[77:76], v[75:64], {96'h0, v[63:32]}, rd);
      if (!v[78])
        check(rd == {96'h0, v[31:0]}, $sformatf("R5-vec%0d data", i), rd, {96'h0, v[31:0]});
    end

    // R9: quad write with offset, then long and quad reads
    qd = 128'h44444444_33333333_22222222_11111111;
    do_op(5, 1'b1, 2'd3, 12'h10C, qd, rd);
    do_op(0, 1'b0, 2'd2, 12'h104, '0, rd);
    check(rd == 128'h22222222, "R9 long in group", rd, 128'h22222222);
    do_op(6, 1'b0, 2'd3, 12'h10F, '0, rd);
    check(rd == qd, "R9 quad read", rd, qd);
    do_op(4, 1'b0, 2'd2, 12'h040, '0, rd);
    check(rd == 128'h556611DD, "R9 other group untouched", rd, 128'h556611DD);

    // R1 R2 R3: all cores at once, served in slot order
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      req[c] = 1'b1; we[c] = 1'b0; size[c] = 2'd2; addr[c] = 12'h040;
    end
    pend = '1;
    for (int k = 0; k < NC; k++) begin
      logic [NC-1:0] exp_r;
      @(negedge clk);
      exp_r = NC'(1) << ((edge_cnt - 1) % NC);
      check(ready == exp_r && rdata == 128'h556611DD, "R1 slot order",
            {ready, rdata[119:0]}, {exp_r, 120'h556611DD});
      pend = pend & ~ready;
      req  = req & ~ready;
    end
    check(pend == '0, "R2 all served", 128'(pend), 128'h0);

    // R4: idle slots produce no ready
    spurious = 0;
    repeat (2 * NC) begin
      @(negedge clk);
      if (ready != '0) spurious++;
    end
    check(spurious == 0, "R4 idle", 128'(spurious), 128'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule